// File: doc/BRIEF.md
# Integer Compare and Clipping Flag Unit

This block compares two 32-bit two's complement integers by forming the second operand minus the first. The difference is thrown away, and only an 8-bit condition code register (CCR) changes. Each compare updates four arithmetic flags: borrow, overflow, zero and negative. Three more flags are sticky and support the trivial accept and reject tests used when clipping a line segment against a bound. A compare can clear these sticky flags or leave them as they are, but it never sets them. An OR-immediate operation on the CCR presets them all at once.

A sequencer raises `inValid` for one cycle with an operation code and the operands. The CCR reflects the result after the next rising clock edge, and `done` is high for that same cycle. Operation codes:

| Code | Operation |
|---|---|
| 0 | plain compare |
| 1 | compare-greater |
| 2 | OR-immediate into the CCR (the immediate is `srcA[7:0]`) |
| 3 | reserved |

CCR layout:

| Bit | Flag |
|---|---|
| 0 | C, borrow |
| 1 | V, overflow |
| 2 | Z, zero |
| 3 | N, negative |
| 4 | I, not written by compares |
| 5 | LR, low-bound test |
| 6 | R, reject |
| 7 | A, accept |

An OR-immediate of 0xE0 therefore sets A, R and LR.

Top module: `cmp_ccr_unit`

## Requirements
- R1: A synchronous reset clears all eight CCR bits and `done` to 0.
- R2: `done` is high in exactly the cycle after each cycle with `inValid` high. With `inValid` low, the CCR holds its value.
- R3: On a compare (op 0 or 1), CCR bit 0 is set when `srcB` is below `srcA` taken as unsigned, that is when the subtraction borrows. It is cleared otherwise.
- R4: On a compare, CCR bit 1 is set when `srcB - srcA` overflows the signed 32-bit range. It is cleared otherwise.
- R5: On a compare, CCR bit 2 is set when the 32-bit difference is zero. CCR bit 3 is set when bit 31 of the difference is one. Each is cleared otherwise.
- R6: On a plain compare (op 0), LR (bit 5) is cleared when `srcB >= srcA` as signed values. In every other case it is unchanged.
- R7: A plain compare leaves I (bit 4), R (bit 6) and A (bit 7) unchanged.
- R8: On a compare-greater (op 1), R (bit 6) is cleared when `srcB < srcA` as signed values and LR was already 0. Otherwise R is unchanged. I, LR and A are unchanged, and bits 0 to 3 follow R3 to R5.
- R9: OR-immediate (op 2) sets every CCR bit that is set in `srcA[7:0]` and leaves the other bits unchanged. With 0xE0 it sets A, R and LR.
- R10: The reserved code (op 3) leaves the CCR unchanged but still produces `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operation strobe |
| inOp | input | 2 | Operation code |
| srcA | input | 32 | Subtrahend; low byte is the OR immediate |
| srcB | input | 32 | Minuend |
| ccr | output | 8 | Condition code register |
| done | output | 1 | Completion pulse |

## Verification
The assertions assume that `inValid`, `inOp` and both operands hold known values at every sampled edge. They also assume that operands are read only in cycles where `inValid` is high, so they say nothing about the CCR across idle operand changes except that it holds. The stimulus drives every input on the falling edge and keeps it steady through the next rising edge. It uses all four operation codes, including the reserved one. Between operations it parks the strobe low, and it does not leave operands unknown after reset.

// File: rtl/cmp_ccr_pkg.sv
package cmp_ccr_pkg;

  localparam int CCR_W = 8;

  localparam int BIT_C  = 0;
  localparam int BIT_V  = 1;
  localparam int BIT_Z  = 2;
  localparam int BIT_N  = 3;
  localparam int BIT_I  = 4;
  localparam int BIT_LR = 5;
  localparam int BIT_R  = 6;
  localparam int BIT_A  = 7;

  typedef enum logic [1:0] {
    OP_CMP   = 2'd0,
    OP_CMPG  = 2'd1,
    OP_ORCCR = 2'd2,
    OP_RSVD  = 2'd3
  } cmpOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic updArith;  // write C, V, Z, N
    logic updLr;     // apply plain-compare LR rule
    logic updR;      // apply compare-greater R rule
    logic orImm;     // OR immediate into CCR
  } ccrStrb_t;

endpackage

// File: rtl/cmp_ccr_ctrl.sv
module cmp_ccr_ctrl
  import cmp_ccr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [1:0] inOp,
  output ccrStrb_t   strb,
  output logic       done
);

  cmpOp_e opDec;

  always_comb begin
    opDec = cmpOp_e'(inOp);
    strb  = '0;
    if (inValid) begin
      unique case (opDec)
        OP_CMP: begin
          strb.updArith = 1'b1;
          strb.updLr    = 1'b1;
        end
        OP_CMPG: begin
          strb.updArith = 1'b1;
          strb.updR     = 1'b1;
        end
        OP_ORCCR: strb.orImm = 1'b1;
        default:  strb = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= inValid;
  end

endmodule

// File: rtl/cmp_ccr_dp.sv
module cmp_ccr_dp
  import cmp_ccr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  ccrStrb_t          strb,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [CCR_W-1:0]  ccr
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0]   diffExt;
  logic [DATA_W-1:0] diff;
  logic              borrowFlag;
  logic              ovfFlag;
  logic              zeroFlag;
  logic              negFlag;
  logic              signedLess;
  logic [CCR_W-1:0]  ccrNext;

  // subtract with one extra bit to catch the borrow
  always_comb begin
    diffExt    = {1'b0, srcB} - {1'b0, srcA};
    diff       = diffExt[DATA_W-1:0];
    borrowFlag = diffExt[DATA_W];
    ovfFlag    = (srcA[MSB] != srcB[MSB]) && (diff[MSB] != srcB[MSB]);
    zeroFlag   = (diff == '0);
    negFlag    = diff[MSB];
    signedLess = negFlag ^ ovfFlag;
  end

  always_comb begin
    ccrNext = ccr;
    if (strb.updArith) begin
      ccrNext[BIT_C] = borrowFlag;
      ccrNext[BIT_V] = ovfFlag;
      ccrNext[BIT_Z] = zeroFlag;
      ccrNext[BIT_N] = negFlag;
    end
    if (strb.updLr && !signedLess)
      ccrNext[BIT_LR] = 1'b0;
    if (strb.updR && signedLess && !ccr[BIT_LR])
      ccrNext[BIT_R] = 1'b0;
    if (strb.orImm)
      ccrNext = ccr | srcA[CCR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) ccr <= '0;
    else     ccr <= ccrNext;
  end

endmodule

// File: rtl/cmp_ccr_unit.sv
module cmp_ccr_unit
  import cmp_ccr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [1:0]        inOp,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [CCR_W-1:0]  ccr,
  output logic              done
);

  ccrStrb_t strb;

  cmp_ccr_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inOp    (inOp),
    .strb    (strb),
    .done    (done)
  );

  cmp_ccr_dp #(.DATA_W(DATA_W)) u_dp (
    .clk  (clk),
    .rst  (rst),
    .strb (strb),
    .srcA (srcA),
    .srcB (srcB),
    .ccr  (ccr)
  );

endmodule

// File: rtl/cmp_ccr_chk.sv
module cmp_ccr_chk
  import cmp_ccr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [1:0]        inOp,
  input logic [DATA_W-1:0] srcA,
  input logic [DATA_W-1:0] srcB,
  input logic [CCR_W-1:0]  ccr,
  input logic              done
);

  logic isCmp, isPlain, isGreater, isOr, isRsvd;
  assign isCmp     = inValid && (inOp == OP_CMP || inOp == OP_CMPG);
  assign isPlain   = inValid && inOp == OP_CMP;
  assign isGreater = inValid && inOp == OP_CMPG;
  assign isOr      = inValid && inOp == OP_ORCCR;
  assign isRsvd    = inValid && inOp == OP_RSVD;

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    inValid |=> done);
  p_no_done_r2: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !done);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ccr == $past(ccr));
  p_borrow_r3: assert property (@(posedge clk) disable iff (rst)
    isCmp |=> ccr[BIT_C] == ($past(srcB) < $past(srcA)));
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    isCmp && (srcA[DATA_W-1] == srcB[DATA_W-1]) |=> !ccr[BIT_V]);
  p_zero_r5: assert property (@(posedge clk) disable iff (rst)
    isCmp |=> ccr[BIT_Z] == ($past(srcA) == $past(srcB)));
  p_lr_clear_r6: assert property (@(posedge clk) disable iff (rst)
    isPlain && ($signed(srcB) >= $signed(srcA)) |=> !ccr[BIT_LR]);
  p_keep_flags_r7: assert property (@(posedge clk) disable iff (rst)
    isPlain |=> ccr[BIT_I] == $past(ccr[BIT_I]) && ccr[BIT_R] == $past(ccr[BIT_R])
               && ccr[BIT_A] == $past(ccr[BIT_A]));
  p_r_clear_r8: assert property (@(posedge clk) disable iff (rst)
    isGreater && ($signed(srcB) < $signed(srcA)) && !ccr[BIT_LR] |=> !ccr[BIT_R]);
  p_keep_lr_r8: assert property (@(posedge clk) disable iff (rst)
    isGreater |=> ccr[BIT_LR] == $past(ccr[BIT_LR]) && ccr[BIT_A] == $past(ccr[BIT_A]));
  p_or_sets_r9: assert property (@(posedge clk) disable iff (rst)
    isOr |=> (ccr & $past(srcA[CCR_W-1:0])) == $past(srcA[CCR_W-1:0]));
  p_rsvd_hold_r10: assert property (@(posedge clk) disable iff (rst)
    isRsvd |=> ccr == $past(ccr));

endmodule

bind cmp_ccr_unit cmp_ccr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .inValid (inValid),
  .inOp    (inOp),
  .srcA    (srcA),
  .srcB    (srcB),
  .ccr     (ccr),
  .done    (done)
);

// File: tb/cmp_ccr_unit_bench.sv
`timescale 1ns/1ps
module cmp_ccr_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [1:0]  inOp = 2'd0;
  logic [31:0] srcA = '0;
  logic [31:0] srcB = '0;
  logic [7:0]  ccr;
  logic        done;

  int checks = 0;
  int fails  = 0;

  logic [7:0] expCcr  = '0;
  logic       expDone = 1'b0;
  int         lastOp  = -1;
  bit         running = 1'b0;

  always #2.5 clk = ~clk;

  cmp_ccr_unit u_cmp_ccr_unit (
    .clk(clk), .rst(rst), .inValid(inValid), .inOp(inOp),
    .srcA(srcA), .srcB(srcB), .ccr(ccr), .done(done)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced on each rising edge
  always @(posedge clk) begin
    if (rst) begin
      expCcr  = '0;
      expDone = 1'b0;
      lastOp  = -1;
    end else begin
      expDone = inValid;
      lastOp  = inValid ? int'(inOp) : -1;
      if (inValid) begin
        longint sa, sb, d;
        bit lt;
        sa = longint'($signed(srcA));
        sb = longint'($signed(srcB));
        d  = sb - sa;
        lt = sb < sa;
        if (inOp == 2'd0 || inOp == 2'd1) begin
          expCcr[0] = ({32'd0, srcB} < {32'd0, srcA});
          expCcr[1] = (d > 64'sd2147483647) || (d < -64'sd2147483648);
          expCcr[2] = (srcB == srcA);
          expCcr[3] = (srcB - srcA) >= 32'h8000_0000;
          if (inOp == 2'd0 && !lt) expCcr[5] = 1'b0;
          if (inOp == 2'd1 && lt && !expCcr[5]) expCcr[6] = 1'b0;
        end else if (inOp == 2'd2) begin
          expCcr = expCcr | srcA[7:0];
        end
      end
    end
  end

  // compare outputs every cycle on the falling edge
  always @(negedge clk) begin
    if (running) begin
      chk("R2 done", {31'd0, done}, {31'd0, expDone});
      chk("R3 C", {31'd0, ccr[0]}, {31'd0, expCcr[0]});
      chk("R4 V", {31'd0, ccr[1]}, {31'd0, expCcr[1]});
      chk("R5 Z/N", {30'd0, ccr[3:2]}, {30'd0, expCcr[3:2]});
      chk("R7 I", {31'd0, ccr[4]}, {31'd0, expCcr[4]});
      chk("R6 LR", {31'd0, ccr[5]}, {31'd0, expCcr[5]});
      chk("R8 R", {31'd0, ccr[6]}, {31'd0, expCcr[6]});
      chk("R9 A", {31'd0, ccr[7]}, {31'd0, expCcr[7]});
      if (lastOp == 3) chk("R10 reserved", {24'd0, ccr}, {24'd0, expCcr});
    end
  end

  task automatic doOp(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    inValid = 1'b1; inOp = op; srcA = a; srcB = b;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset ccr", {24'd0, ccr}, 32'd0);
    chk("R1 reset done", {31'd0, done}, 32'd0);
    rst = 1'b0;
    running = 1'b1;
    // clipping scenario: preset, then tests
    doOp(2'd2, 32'hE0, 0);                   // R9 preset A,R,LR
    doOp(2'd0, 32'd10, 32'd5);               // R6 S2<S1: LR kept
    doOp(2'd1, 32'd10, 32'd5);               // R8 LR set: R kept
    doOp(2'd0, 32'd5, 32'd10);               // R6 LR cleared
    doOp(2'd1, 32'd10, 32'd5);               // R8 R cleared
    doOp(2'd0, 32'd7, 32'd7);                // R5 zero
    doOp(2'd0, 32'h0000_0001, 32'h8000_0000); // R4 overflow
    doOp(2'd0, 32'hFFFF_FFFF, 32'h7FFF_FFFF); // R4 overflow
    doOp(2'd0, 32'h0000_0001, 32'h0000_0000); // R3 borrow, negative
    doOp(2'd2, 32'h10, 0);                   // R9 I bit
    doOp(2'd3, 32'hFF, 32'h1);               // R10 reserved
    doOp(2'd1, 32'h1, 32'h0);                // R8 with LR clear
    repeat (2) @(negedge clk);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = (i % 7 == 0) ? a : $urandom;
      if (i % 11 == 0) b = a ^ 32'h8000_0000;
      doOp(2'($urandom_range(0, 3)), a, b);
      if (i % 5 == 0) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset again", {24'd0, ccr}, 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule